// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block is a passive observer that sits on the registered control pins of a two-bank SDRAM interface. On every rising clock edge it samples chip select, the three strobes, clock enable, the bank select bit, address bit 10 and the data mask. It decodes the command and presents it as a small code one cycle later. It also keeps an open/idle flag for each bank. It never drives the memory and holds no data.

Alongside the decode, the block checks the command stream against the timing rules of the memory, counted in clock cycles. It flags activate-to-access, activate-to-precharge, precharge-to-activate, activate-to-activate, refresh recovery and mode-register recovery. It also flags commands that are illegal in the current bank state, and accesses issued while a self-closing burst is still running. Each rule owns one sticky bit, so a higher-level monitor can read which rule broke first. The block also produces the two data-mask effects: write beats masked in the same cycle, and read output forced to high impedance two cycles after the mask is sampled. A low clock enable freezes the next cycle, which models clock suspend.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With clock enable seen high on the previous edge, chip select high yields code 8 (deselect), and chip select low with all three strobes high yields code 0 (no operation). The code appears on `cmdCode` in the cycle after the sampling edge.
- R2: With chip select low, the strobes {ras,cas,we} (active low) decode as follows: 000 to code 1 (mode set), 001 to 2 (refresh), 011 to 3 (activate), 101 to 4 (read), 100 to 5 (write), 010 to 6 (precharge) and 110 to 7 (burst stop).
- R3: An activate opens the bank named by `bankSel` (0 maps to `bankActive[0]`). A precharge with `a10` low closes only the selected bank. A precharge with `a10` high closes both banks and ignores `bankSel`.
- R4: A read or write to an open bank with `a10` high closes that bank BURST_LEN edges after the command edge, that is, on the edge after the last beat. That edge also starts the bank's precharge-to-activate timer.
- R5: A mode set or a refresh while either bank is open sets violation bit 0.
- R6: Any command other than no-op or deselect sets bit 1 if it comes fewer than T_MRD edges after a mode set. It sets bit 8 if it comes fewer than T_RFC edges after a refresh.
- R7: A read or write to an idle bank sets bit 3. To an open bank fewer than T_RCD edges after its activate, it sets bit 2.
- R8: Bit 4 is set by a precharge of an open bank fewer than T_RAS edges after its activate. Bit 5 is set by an activate fewer than T_RP edges after that bank closed. Bit 6 is set by an activate to a bank that is already open. Bit 7 is set by an activate fewer than T_RRD edges after an activate to the other bank.
- R9: A read or write issued before an auto-closing burst has delivered its last beat sets bit 9.
- R10: Violation bits stay set until reset.
- R11: Clock enable low at an edge makes the next edge a suspended edge. That edge shows code 9, changes no bank state, sets no violation and leaves all timers unchanged.
- R12: `rdHiZ` is high in the cycle that starts two edges after the edge where the mask was sampled high. `wrMask` is high in the cycle after an edge that sampled the mask high on a write beat (the write edge and the following BURST_LEN-1 active edges, cut short by a read or burst stop).
- R13: After reset, `cmdCode` is 0, both banks are idle, and all violation bits, `rdHiZ` and `wrMask` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge samples everything |
| rstN | input | 1 | Synchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable |
| bankSel | input | 1 | Bank select bit |
| a10 | input | 1 | Address bit 10: all-bank precharge or auto-close |
| dqm | input | 1 | Data mask |
| cmdCode | output | 4 | Decoded command of the previous edge |
| bankActive | output | 2 | Per-bank open flag |
| violation | output | 10 | Sticky rule-violation bits |
| rdHiZ | output | 1 | Read data forced to high impedance |
| wrMask | output | 1 | Write beat masked |

## Verification
The bench shortens the timing parameters to T_RCD=3, T_RP=3, T_RAS=5, T_RRD=2, T_RFC=6, T_MRD=2 and BURST_LEN=4. With these values, short random command streams regularly land exactly at and one cycle inside every window. The short burst lets auto-close, its busy window and the write-mask beat span all complete within a few steps. That leaves room for back-to-back bank interactions and suspend cycles inside the same short epoch between resets.

// File: rtl/sdmon_pkg.sv
`timescale 1ns/1ps
package sdmon_pkg;
  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_MRS   = 4'd1,
    CMD_REF   = 4'd2,
    CMD_ACT   = 4'd3,
    CMD_RD    = 4'd4,
    CMD_WR    = 4'd5,
    CMD_PRE   = 4'd6,
    CMD_BST   = 4'd7,
    CMD_DESEL = 4'd8,
    CMD_SUSP  = 4'd9
  } cmd_e;

  localparam int NUM_VIOL = 10;
  localparam int V_BUSY   = 0;
  localparam int V_MRD    = 1;
  localparam int V_RCD    = 2;
  localparam int V_IDLE   = 3;
  localparam int V_RAS    = 4;
  localparam int V_RP     = 5;
  localparam int V_REOPEN = 6;
  localparam int V_RRD    = 7;
  localparam int V_RFC    = 8;
  localparam int V_APBUSY = 9;

  // strobes from decode control to bank datapath
  typedef struct packed {
    logic en;
    logic any;
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic preAll;
    logic mrs;
    logic refr;
    logic bst;
    logic ap;
    logic bank;
  } strobe_t;

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdmon_ctrl.sv
`timescale 1ns/1ps
module sdmon_ctrl import sdmon_pkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    rasN,
  input  logic    casN,
  input  logic    weN,
  input  logic    cke,
  input  logic    bankSel,
  input  logic    a10,
  output strobe_t stb,
  output cmd_e    cmdCode
);
  logic ckeQ;
  cmd_e code;

  always_ff @(posedge clk) begin
    if (!rstN) ckeQ <= 1'b1;
    else       ckeQ <= cke;
  end

  always_comb begin
    if (!ckeQ)    code = CMD_SUSP;
    else if (csN) code = CMD_DESEL;
    else begin
      case ({rasN, casN, weN})
        3'b000:  code = CMD_MRS;
        3'b001:  code = CMD_REF;
        3'b011:  code = CMD_ACT;
        3'b101:  code = CMD_RD;
        3'b100:  code = CMD_WR;
        3'b010:  code = CMD_PRE;
        3'b110:  code = CMD_BST;
        default: code = CMD_NOP;
      endcase
    end
  end

  always_comb begin
    stb.en     = ckeQ;
    stb.any    = !(code inside {CMD_NOP, CMD_DESEL, CMD_SUSP});
    stb.act    = (code == CMD_ACT);
    stb.rd     = (code == CMD_RD);
    stb.wr     = (code == CMD_WR);
    stb.pre    = (code == CMD_PRE);
    stb.mrs    = (code == CMD_MRS);
    stb.refr   = (code == CMD_REF);
    stb.bst    = (code == CMD_BST);
    stb.preAll = a10;
    stb.ap     = a10;
    stb.bank   = bankSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cmdCode <= CMD_NOP;
    else       cmdCode <= code;
  end
endmodule

// File: rtl/sdmon_path.sv
`timescale 1ns/1ps
module sdmon_path import sdmon_pkg::*; #(
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 7,
  parameter int T_RRD     = 2,
  parameter int T_RFC     = 10,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic                dqm,
  output logic [1:0]          bankActive,
  output logic [NUM_VIOL-1:0] violation,
  output logic                rdHiZ,
  output logic                wrMask
);
  localparam int NB   = 2;
  localparam int TMAX = maxInt(maxInt(maxInt(T_RCD, T_RP), maxInt(T_RAS, T_RRD)),
                               maxInt(T_RFC, T_MRD));
  localparam int CW   = $clog2(TMAX + 1) + 1;
  localparam int AW   = $clog2(BURST_LEN + 1);
  localparam logic [CW-1:0] SAT = '1;

  function automatic logic [CW-1:0] satInc(input logic [CW-1:0] x);
    return (x == SAT) ? x : x + 1'b1;
  endfunction

  logic [NUM_VIOL-1:0] bankViol [NB];
  logic [NUM_VIOL-1:0] globViol;
  logic [CW-1:0]       sinceMrs, sinceRef;
  logic [AW-1:0]       wrLeft;
  logic [2:0]          dqmPipe;
  logic                accessAny;

  assign accessAny = stb.rd || stb.wr;

  for (genvar gb = 0; gb < NB; gb++) begin : g_bank
    logic                isOpen, hit, preHit, apDone, access;
    logic [CW-1:0]       sinceAct, sincePre;
    logic [AW-1:0]       apCnt;
    logic [NUM_VIOL-1:0] v;

    assign hit    = (stb.bank == 1'(gb));
    assign preHit = stb.pre && (stb.preAll || hit);
    assign apDone = stb.en && (apCnt == AW'(1));
    assign access = accessAny && hit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        isOpen   <= 1'b0;
        sinceAct <= SAT;
        sincePre <= SAT;
        apCnt    <= '0;
      end else if (stb.en) begin
        sinceAct <= (stb.act && hit) ? CW'(1) : satInc(sinceAct);
        sincePre <= ((preHit && isOpen) || apDone) ? CW'(1) : satInc(sincePre);
        if (stb.act && hit)          isOpen <= 1'b1;
        else if (preHit || apDone)   isOpen <= 1'b0;
        if (access && stb.ap && isOpen) apCnt <= AW'(BURST_LEN);
        else if (apCnt != '0)           apCnt <= apCnt - 1'b1;
      end
    end

    always_comb begin
      v           = '0;
      v[V_BUSY]   = (stb.mrs || stb.refr) && isOpen;
      v[V_IDLE]   = access && !isOpen;
      v[V_RCD]    = access && isOpen && (sinceAct < CW'(T_RCD));
      v[V_APBUSY] = accessAny && (apCnt > AW'(1));
      v[V_RAS]    = preHit && isOpen && (sinceAct < CW'(T_RAS));
      v[V_RP]     = stb.act && hit && (sincePre < CW'(T_RP));
      v[V_REOPEN] = stb.act && hit && isOpen;
      v[V_RRD]    = stb.act && !hit && (sinceAct < CW'(T_RRD));
    end

    assign bankViol[gb]   = v;
    assign bankActive[gb] = isOpen;
  end

  always_comb begin
    globViol        = '0;
    globViol[V_MRD] = stb.any && (sinceMrs < CW'(T_MRD));
    globViol[V_RFC] = stb.any && (sinceRef < CW'(T_RFC));
    for (int b = 0; b < NB; b++) globViol = globViol | bankViol[b];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      violation <= '0;
      sinceMrs  <= SAT;
      sinceRef  <= SAT;
      wrLeft    <= '0;
      wrMask    <= 1'b0;
      dqmPipe   <= '0;
    end else begin
      dqmPipe <= {dqmPipe[1:0], dqm};
      wrMask  <= dqm && (stb.wr || (stb.en && wrLeft != '0));
      if (stb.en) begin
        violation <= violation | globViol;
        sinceMrs  <= stb.mrs  ? CW'(1) : satInc(sinceMrs);
        sinceRef  <= stb.refr ? CW'(1) : satInc(sinceRef);
        if (stb.wr)                 wrLeft <= AW'(BURST_LEN - 1);
        else if (stb.rd || stb.bst) wrLeft <= '0;
        else if (wrLeft != '0)      wrLeft <= wrLeft - 1'b1;
      end
    end
  end

  assign rdHiZ = dqmPipe[2];
endmodule

// File: rtl/sdram_cmd_monitor.sv
`timescale 1ns/1ps
module sdram_cmd_monitor import sdmon_pkg::*; #(
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 7,
  parameter int T_RRD     = 2,
  parameter int T_RFC     = 10,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                rasN,
  input  logic                casN,
  input  logic                weN,
  input  logic                cke,
  input  logic                bankSel,
  input  logic                a10,
  input  logic                dqm,
  output logic [3:0]          cmdCode,
  output logic [1:0]          bankActive,
  output logic [NUM_VIOL-1:0] violation,
  output logic                rdHiZ,
  output logic                wrMask
);
  strobe_t stb;
  cmd_e    codeQ;

  sdmon_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .bankSel(bankSel), .a10(a10), .stb(stb), .cmdCode(codeQ)
  );

  sdmon_path #(
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RRD(T_RRD),
    .T_RFC(T_RFC), .T_MRD(T_MRD), .BURST_LEN(BURST_LEN)
  ) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .dqm(dqm), .bankActive(bankActive),
    .violation(violation), .rdHiZ(rdHiZ), .wrMask(wrMask)
  );

  assign cmdCode = codeQ;
endmodule

// File: rtl/sdmon_checker.sv
`timescale 1ns/1ps
module sdmon_checker import sdmon_pkg::*; (
  input logic                clk,
  input logic                rstN,
  input logic                stbEn,
  input logic                stbAct,
  input logic                stbPre,
  input logic                stbPreAll,
  input logic                stbBank,
  input logic                csN,
  input logic                dqm,
  input logic [3:0]          cmdCode,
  input logic [1:0]          bankActive,
  input logic [NUM_VIOL-1:0] violation,
  input logic                rdHiZ
);
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rstN)            cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 1'b1;
  end

  AST_DESEL_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (stbEn && csN) |=> (cmdCode == CMD_DESEL)); // R1

  AST_SUSPEND_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    !stbEn |=> ($stable(bankActive) && cmdCode == CMD_SUSP)); // R11

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    stbAct |=> ((bankActive & ($past(stbBank) ? 2'b10 : 2'b01)) != 2'b00)); // R3

  AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (stbPre && stbPreAll) |=> (bankActive == 2'b00)); // R3

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((violation & $past(violation)) == $past(violation))); // R10

  AST_HIZ_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd3) |-> (rdHiZ == $past(dqm, 3))); // R12
endmodule

bind sdram_cmd_monitor sdmon_checker u_chk (
  .clk(clk), .rstN(rstN), .stbEn(stb.en), .stbAct(stb.act), .stbPre(stb.pre),
  .stbPreAll(stb.preAll), .stbBank(stb.bank), .csN(csN), .dqm(dqm),
  .cmdCode(cmdCode), .bankActive(bankActive), .violation(violation), .rdHiZ(rdHiZ)
);

// File: tb/sdram_cmd_monitor_bench.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_bench;
  import sdmon_pkg::*;
  localparam int P_RCD = 3, P_RP = 3, P_RAS = 5, P_RRD = 2, P_RFC = 6, P_MRD = 2, P_BL = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, cke = 1'b1;
  logic bankSel = 1'b0, a10 = 1'b0, dqm = 1'b0;
  logic [3:0] cmdCode;
  logic [1:0] bankActive;
  logic [NUM_VIOL-1:0] violation;
  logic rdHiZ, wrMask;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_monitor #(.T_RCD(P_RCD), .T_RP(P_RP), .T_RAS(P_RAS), .T_RRD(P_RRD),
    .T_RFC(P_RFC), .T_MRD(P_MRD), .BURST_LEN(P_BL)) u_sdram_cmd_monitor (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .bankSel(bankSel), .a10(a10), .dqm(dqm), .cmdCode(cmdCode),
    .bankActive(bankActive), .violation(violation), .rdHiZ(rdHiZ), .wrMask(wrMask));

  // reference state
  int nAct, lastMrs, lastRef, wrEnd;
  int lastAct[2], lastPre[2], apAt[2];
  bit mCke, h1, h2;
  bit mOpen[2];
  logic [3:0] eCode;
  logic [NUM_VIOL-1:0] eViol;
  bit eHiZ, eMask;

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, got, exp, $time);
    end
  endtask

  function automatic string violReq(input int i);
    case (i)
      V_BUSY:                       return "R5 busy";
      V_MRD:                        return "R6 mode gap";
      V_RFC:                        return "R6 refresh gap";
      V_RCD:                        return "R7 tRCD";
      V_IDLE:                       return "R7 idle access";
      V_RAS:                        return "R8 tRAS";
      V_RP:                         return "R8 tRP";
      V_REOPEN:                     return "R8 reopen";
      V_RRD:                        return "R8 tRRD";
      default:                      return "R9 autoclose busy";
    endcase
  endfunction

  task automatic modelReset();
    nAct = 0; lastMrs = -1000; lastRef = -1000; wrEnd = -1000;
    for (int b = 0; b < 2; b++) begin
      lastAct[b] = -1000; lastPre[b] = -1000; apAt[b] = -1; mOpen[b] = 1'b0;
    end
    mCke = 1'b1; h1 = 1'b0; h2 = 1'b0;
    eCode = 4'd0; eViol = '0; eHiZ = 1'b0; eMask = 1'b0;
  endtask

  task automatic modelEdge();
    bit en, act, rd, wr, pre, mrs, rf, bst, any, hit, preHit, apDone;
    cmd_e code;
    en = mCke; mCke = cke;
    eHiZ = h2; h2 = h1; h1 = dqm;
    if (!en) code = CMD_SUSP;
    else if (csN) code = CMD_DESEL;
    else case ({rasN, casN, weN})
      3'b000: code = CMD_MRS;
      3'b001: code = CMD_REF;
      3'b011: code = CMD_ACT;
      3'b101: code = CMD_RD;
      3'b100: code = CMD_WR;
      3'b010: code = CMD_PRE;
      3'b110: code = CMD_BST;
      default: code = CMD_NOP;
    endcase
    eCode = code;
    eMask = 1'b0;
    if (en) begin
      nAct++;
      act = (code == CMD_ACT); rd = (code == CMD_RD); wr = (code == CMD_WR);
      pre = (code == CMD_PRE); mrs = (code == CMD_MRS); rf = (code == CMD_REF);
      bst = (code == CMD_BST); any = !(code == CMD_NOP || code == CMD_DESEL);
      eMask = dqm && (wr || nAct <= wrEnd);
      if ((mrs || rf) && (mOpen[0] || mOpen[1])) eViol[V_BUSY] = 1'b1;
      if (any && nAct - lastMrs < P_MRD) eViol[V_MRD] = 1'b1;
      if (any && nAct - lastRef < P_RFC) eViol[V_RFC] = 1'b1;
      for (int b = 0; b < 2; b++) begin
        hit = (bankSel == 1'(b)); preHit = pre && (a10 || hit);
        if ((rd || wr) && hit) begin
          if (!mOpen[b]) eViol[V_IDLE] = 1'b1;
          else if (nAct - lastAct[b] < P_RCD) eViol[V_RCD] = 1'b1;
        end
        if ((rd || wr) && nAct < apAt[b]) eViol[V_APBUSY] = 1'b1;
        if (preHit && mOpen[b] && nAct - lastAct[b] < P_RAS) eViol[V_RAS] = 1'b1;
        if (act && hit) begin
          if (nAct - lastPre[b] < P_RP) eViol[V_RP] = 1'b1;
          if (mOpen[b]) eViol[V_REOPEN] = 1'b1;
        end
        if (act && !hit && nAct - lastAct[b] < P_RRD) eViol[V_RRD] = 1'b1;
      end
      for (int b = 0; b < 2; b++) begin
        hit = (bankSel == 1'(b)); preHit = pre && (a10 || hit);
        apDone = (apAt[b] == nAct);
        if ((preHit && mOpen[b]) || apDone) lastPre[b] = nAct;
        if ((rd || wr) && hit && a10 && mOpen[b]) apAt[b] = nAct + P_BL;
        if (act && hit) begin mOpen[b] = 1'b1; lastAct[b] = nAct; end
        else if (preHit || apDone) mOpen[b] = 1'b0;
      end
      if (wr) wrEnd = nAct + P_BL - 1;
      else if (rd || bst) wrEnd = -1000;
      if (mrs) lastMrs = nAct;
      if (rf) lastRef = nAct;
    end
  endtask

  task automatic step(input bit cs, input bit ras, input bit cas, input bit we,
                      input bit ba, input bit a, input bit dq, input bit ck);
    @(negedge clk);
    csN = cs; rasN = ras; casN = cas; weN = we; bankSel = ba; a10 = a; dqm = dq; cke = ck;
    modelEdge();
    @(posedge clk);
    #1;
    check("R1/R2/R11 command code", cmdCode, eCode);
    check("R3/R4/R11 bank state", bankActive, {mOpen[1], mOpen[0]});
    for (int i = 0; i < NUM_VIOL; i++) check(violReq(i), violation[i], eViol[i]);
    check("R12 read hi-z", rdHiZ, eHiZ);
    check("R12 write mask", wrMask, eMask);
  endtask

  task automatic nop(input int n, input bit dq);
    for (int i = 0; i < n; i++) step(0, 1, 1, 1, 0, 0, dq, 1);
  endtask
  task automatic act(input bit b);              step(0, 0, 1, 1, b, 0, 0, 1); endtask
  task automatic rdc(input bit b, input bit ap); step(0, 1, 0, 1, b, ap, 0, 1); endtask
  task automatic wrc(input bit b, input bit ap, input bit dq); step(0, 1, 0, 0, b, ap, dq, 1); endtask
  task automatic prec(input bit b, input bit all); step(0, 0, 1, 0, b, all, 0, 1); endtask
  task automatic mrsc();                        step(0, 0, 0, 0, 0, 0, 0, 1); endtask
  task automatic refc();                        step(0, 0, 0, 1, 0, 0, 0, 1); endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; csN = 1'b1; rasN = 1'b1; casN = 1'b1; weN = 1'b1;
    cke = 1'b1; bankSel = 1'b0; a10 = 1'b0; dqm = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  task automatic randomStep();
    int r;
    bit ba, a, dq, ck;
    r = $urandom_range(0, 9);
    ba = 1'($urandom_range(0, 1)); a = ($urandom_range(0, 3) == 0);
    dq = 1'($urandom_range(0, 1)); ck = ($urandom_range(0, 7) != 0);
    case (r)
      0: step(1, 0, 0, 0, ba, a, dq, ck);
      1: step(0, 0, 0, 0, ba, a, dq, ck);
      2: step(0, 0, 0, 1, ba, a, dq, ck);
      3, 4: step(0, 0, 1, 1, ba, a, dq, ck);
      5: step(0, 1, 0, 1, ba, a, dq, ck);
      6: step(0, 1, 0, 0, ba, a, dq, ck);
      7: step(0, 0, 1, 0, ba, a, dq, ck);
      8: step(0, 1, 1, 0, ba, a, dq, ck);
      default: step(0, 1, 1, 1, ba, a, dq, ck);
    endcase
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    // R13 reset state
    doReset();
    #1;
    check("R13 code", cmdCode, 0);
    check("R13 banks", bankActive, 0);
    check("R13 violations", violation, 0);
    check("R13 hi-z", rdHiZ, 0);
    check("R13 mask", wrMask, 0);

    // R1/R2 decode of every encoding, R3 open and close
    doReset();
    step(1, 0, 0, 0, 0, 0, 0, 1);
    check("R1 deselect", cmdCode, 8);
    nop(1, 0);
    check("R1 nop", cmdCode, 0);
    act(0); nop(P_RAS - 1, 0); act(1);
    check("R2 activate", cmdCode, 3);
    nop(P_RAS, 0);
    prec(0, 0);
    check("R3 single precharge", bankActive, 2'b10);
    act(0); nop(P_RAS, 0);
    prec(1, 1);
    check("R3 all-bank precharge", bankActive, 2'b00);
    step(0, 1, 1, 0, 0, 0, 0, 1);
    check("R2 burst stop", cmdCode, 7);

    // R7 tRCD boundary
    doReset();
    act(0); nop(P_RCD - 2, 0); rdc(0, 0);
    check("R7 tRCD one early", violation[V_RCD], 1);
    doReset();
    act(0); nop(P_RCD - 1, 0); rdc(0, 0);
    check("R7 tRCD exact", violation[V_RCD], 0);
    rdc(1, 0);
    check("R7 idle bank read", violation[V_IDLE], 1);

    // R4 auto-close timing and R9 busy window
    doReset();
    act(0); act(1); nop(P_RCD - 1, 0); rdc(0, 1);
    nop(P_BL - 1, 0);
    check("R4 open through last beat", bankActive[0], 1);
    nop(1, 0);
    check("R4 closed after burst", bankActive[0], 0);
    check("R9 no busy after end", violation[V_APBUSY], 0);
    act(0); nop(P_RCD, 0); rdc(0, 1); rdc(1, 0);
    check("R9 access during auto-close burst", violation[V_APBUSY], 1);

    // R5 and R6
    doReset();
    act(0); mrsc();
    check("R5 mode set with open bank", violation[V_BUSY], 1);
    doReset();
    mrsc(); act(0);
    check("R6 command right after mode set", violation[V_MRD], 1);
    doReset();
    refc(); nop(P_RFC - 1, 0); act(0);
    check("R6 refresh recovery exact", violation[V_RFC], 0);

    // R8 and R10
    doReset();
    act(0); act(1);
    check("R8 tRRD", violation[V_RRD], 1);
    act(0);
    check("R8 reopen", violation[V_REOPEN], 1);
    prec(0, 0);
    check("R8 tRAS", violation[V_RAS], 1);
    act(0);
    check("R8 tRP", violation[V_RP], 1);
    nop(12, 0);
    check("R10 sticky", violation[V_RRD], 1);

    // R11 clock suspend
    doReset();
    act(0); nop(P_RAS, 0);
    step(0, 1, 1, 1, 0, 0, 0, 0);
    prec(0, 0);
    check("R11 suspended code", cmdCode, 9);
    check("R11 bank unchanged", bankActive[0], 1);
    prec(0, 0);
    check("R11 precharge after resume", bankActive[0], 0);

    // R12 mask timing
    doReset();
    nop(1, 1); nop(1, 0);
    check("R12 hi-z not yet", rdHiZ, 0);
    nop(1, 0);
    check("R12 hi-z two later", rdHiZ, 1);
    act(0); nop(P_RCD - 1, 0); wrc(0, 0, 0); nop(1, 1);
    check("R12 masked beat", wrMask, 1);
    nop(P_BL - 2, 1); nop(1, 1);
    check("R12 after burst unmasked", wrMask, 0);

    // constrained random epochs
    for (int e = 0; e < 12; e++) begin
      doReset();
      for (int s = 0; s < 30; s++) randomStep();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule